// File: doc/BRIEF.md
# Dynamic Bus Sizing Cycle Splitter

This block sits between a 32-bit processor request port and an external memory bus whose devices may be 32, 16 or 8 bits wide. A device reports its width on two active-low size pins, one meaning "16 bits" and one meaning "8 bits". The block therefore learns the width only while a cycle is in progress. Each accepted read or write is turned into as many bus cycles as the reported widths require. The block keeps a mask of the bytes still to be moved and chooses the next cycle from that mask. Read bytes are collected into one 32-bit word, which is returned on a single completion pulse.

Requests enter through a valid/ready handshake. `req_ready` is high only while the block is idle. A request is taken on the rising edge where `req_valid` and `req_ready` are both high. Back-pressure works by holding `req_ready` low from that edge until the completion pulse has been given. The completion side has no back-pressure: `resp_valid` is high for exactly one cycle. Every bus address passes through an address-bit-20 mask that an active-low input controls.

Top module: `bsz_splitter`

## Requirements
- R1: While reset is held and in the first cycle after it, `req_ready` is 1, and `bus_cyc` and `resp_valid` are 0.
- R2: The width is decoded from the size pins as follows. Both pins high means 32 bits. Only `bus_bs16_n` low means 16 bits. `bus_bs8_n` low means 8 bits, whatever `bus_bs16_n` is.
- R3: The width used on a `bus_rdy_n`-low edge is the pin value captured on the previous rising edge. The pin values present on the ready edge itself have no effect on that cycle.
- R4: A 32-bit answer completes every pending byte in one cycle, and read bytes are taken from their natural lanes. `bus_write` equals the write flag of the request.
- R5: A 16-bit answer completes the pending bytes of one half only, lower half first. That half is the one selected by `bus_addr[1]`, and read bytes are taken from lanes 0-1.
- R6: An 8-bit answer completes exactly one byte, in ascending byte order. That byte is the one selected by `bus_addr[1:0]`, and it is read from lane 0.
- R7: Write data is laid out as follows. Lanes 2 and 3 carry request bytes 2 and 3. Lane 0 carries the request byte at `bus_addr[1:0]`. Lane 1 carries the request byte at index {`bus_addr[1]`, 1}.
- R8: During a cycle, `bus_be` bit i is 1 exactly when byte i is still pending, so it is never 0. `bus_addr[1:0]` is the index of the lowest pending byte. Bytes that the request did not enable get no cycle.
- R9: `bus_addr`, `bus_be` and `bus_wdata` stay constant while `bus_rdy_n` is high. The width may change from one cycle to the next within a request, and the remaining cycles are re-planned each time.
- R10: `resp_valid` is a one-cycle pulse, given once per request, in the cycle after the last ready edge. `resp_rdata` then holds the read bytes, with 0 in lanes that were not enabled.
- R11: A request with `req_be` = 0000 causes no bus cycle. It completes in the cycle after acceptance.
- R12: `bus_addr[31:2]` equals `req_addr[31:2]`, and `req_addr[1:0]` is ignored. While `a20m_n` is low, `bus_addr[20]` is 0.
- R13: `bus_rdy_n` has no effect while no bus cycle is open.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Request offered |
| req_ready | output | 1 | Block idle, request can be taken |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | 32 | Byte address; bits 1:0 ignored |
| req_be | input | 4 | Byte enables of the request |
| req_wdata | input | 32 | Write word |
| resp_valid | output | 1 | One-cycle completion pulse |
| resp_rdata | output | 32 | Assembled read word |
| bus_cyc | output | 1 | A bus cycle is open |
| bus_write | output | 1 | Direction of the open cycle |
| bus_addr | output | 32 | Byte address of the lowest pending byte |
| bus_be | output | 4 | Pending byte mask |
| bus_wdata | output | 32 | Steered write data |
| bus_rdata | input | 32 | Read data from the device |
| bus_rdy_n | input | 1 | Active-low cycle completion |
| bus_bs16_n | input | 1 | Active-low 16-bit width report |
| bus_bs8_n | input | 1 | Active-low 8-bit width report |
| a20m_n | input | 1 | Active-low address bit 20 mask |

## Verification
The size pins are sampled for the next cycle on the same edge where `bus_rdy_n` completes the current cycle, so the two functions coincide. The bench provokes this in two ways. In one test it flips the pins to "32 bits" exactly on ready edges. In another it changes the width between the cycles of one request. In both cases a cycle-by-cycle reference model, which uses only the value captured one edge earlier, judges the bus mask, the address, the number of cycles and the assembled word. The completion pulse and the idle `req_ready` also fall in the cycle after the final ready. The bench checks these against the model on every clock.

// File: rtl/bsz_pkg.sv
package bsz_pkg;
  localparam int unsigned LANES  = 4;
  localparam int unsigned DATA_W = LANES * 8;
  localparam int unsigned OFFS_W = $clog2(LANES);

  typedef enum logic [1:0] {
    W32 = 2'd0,
    W16 = 2'd1,
    W8  = 2'd2
  } bus_width_e;

  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_BUS  = 2'd1,
    ST_DONE = 2'd2
  } split_state_e;

  // R2: the 8-bit report dominates, then the 16-bit report, else full width
  function automatic bus_width_e decode_size(input logic bs16_n, input logic bs8_n);
    if (!bs8_n)       return W8;
    else if (!bs16_n) return W16;
    else              return W32;
  endfunction
endpackage

// File: rtl/bsz_size_sampler.sv
module bsz_size_sampler
  import bsz_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       bs16_n,
  input  logic       bs8_n,
  output bus_width_e width_q
);
  // R3: captured on every edge; the value is consumed one edge later
  always_ff @(posedge clk) begin
    if (!rst_n) width_q <= W32;
    else        width_q <= decode_size(bs16_n, bs8_n);
  end
endmodule

// File: rtl/bsz_lane_plan.sv
module bsz_lane_plan
  import bsz_pkg::*;
(
  input  logic [LANES-1:0]  pend,
  input  bus_width_e        width,
  input  logic [DATA_W-1:0] wword,
  output logic [OFFS_W-1:0] offs,
  output logic [LANES-1:0]  xfer,
  output logic [DATA_W-1:0] steer
);
  localparam logic [LANES-1:0] LO_HALF = {{(LANES/2){1'b0}}, {(LANES/2){1'b1}}};

  logic [OFFS_W-1:0] pair_hi;

  // lowest pending byte
  always_comb begin
    offs = '0;
    for (int i = LANES - 1; i >= 0; i--) begin
      if (pend[i]) offs = OFFS_W'(i);
    end
  end

  assign pair_hi = {offs[OFFS_W-1], 1'b1};

  // bytes the answered width completes
  always_comb begin
    xfer = '0;
    case (width)
      W16: xfer = pend & (offs[OFFS_W-1] ? ~LO_HALF : LO_HALF);
      W8: begin
        for (int b = 0; b < LANES; b++) xfer[b] = (b == int'(offs));
      end
      default: xfer = pend;
    endcase
  end

  // copy the addressed byte and its pair partner down to lanes 0 and 1
  always_comb begin
    steer = wword;
    for (int b = 0; b < LANES; b++) begin
      if (b == int'(offs))    steer[7:0]  = wword[b*8 +: 8];
      if (b == int'(pair_hi)) steer[15:8] = wword[b*8 +: 8];
    end
  end
endmodule

// File: rtl/bsz_read_merge.sv
module bsz_read_merge
  import bsz_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              clear,
  input  logic              capture,
  input  logic [LANES-1:0]  xfer,
  input  bus_width_e        width,
  input  logic [DATA_W-1:0] rdata,
  output logic [DATA_W-1:0] word_q
);
  for (genvar g = 0; g < LANES; g++) begin : g_lane
    logic [7:0] src;
    logic [7:0] byte_q;

    always_comb begin
      case (width)
        W16:     src = rdata[(g % 2)*8 +: 8];
        W8:      src = rdata[7:0];
        default: src = rdata[g*8 +: 8];
      endcase
    end

    always_ff @(posedge clk) begin
      if (!rst_n)                  byte_q <= '0;
      else if (clear)              byte_q <= '0;
      else if (capture && xfer[g]) byte_q <= src;
    end

    assign word_q[g*8 +: 8] = byte_q;
  end
endmodule

// File: rtl/bsz_splitter.sv
module bsz_splitter
  import bsz_pkg::*;
#(
  parameter int unsigned ADDR_W   = 32,
  parameter int unsigned MASK_BIT = 20
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic              req_write,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic [LANES-1:0]  req_be,
  input  logic [DATA_W-1:0] req_wdata,
  output logic              resp_valid,
  output logic [DATA_W-1:0] resp_rdata,
  output logic              bus_cyc,
  output logic              bus_write,
  output logic [ADDR_W-1:0] bus_addr,
  output logic [LANES-1:0]  bus_be,
  output logic [DATA_W-1:0] bus_wdata,
  input  logic [DATA_W-1:0] bus_rdata,
  input  logic              bus_rdy_n,
  input  logic              bus_bs16_n,
  input  logic              bus_bs8_n,
  input  logic              a20m_n
);
  localparam int unsigned BASE_W = ADDR_W - OFFS_W;

  split_state_e      st_q;
  logic [BASE_W-1:0] base_q;
  logic [LANES-1:0]  pend_q;
  logic [LANES-1:0]  pend_nx;
  logic [DATA_W-1:0] wd_q;
  logic              we_q;
  bus_width_e        width_q;
  logic [OFFS_W-1:0] offs;
  logic [LANES-1:0]  xfer;
  logic [DATA_W-1:0] steer;
  logic [ADDR_W-1:0] addr_raw;
  logic              accept;
  logic              cyc_end;

  bsz_size_sampler u_size (
    .clk     (clk),
    .rst_n   (rst_n),
    .bs16_n  (bus_bs16_n),
    .bs8_n   (bus_bs8_n),
    .width_q (width_q)
  );

  bsz_lane_plan u_plan (
    .pend  (pend_q),
    .width (width_q),
    .wword (wd_q),
    .offs  (offs),
    .xfer  (xfer),
    .steer (steer)
  );

  bsz_read_merge u_merge (
    .clk     (clk),
    .rst_n   (rst_n),
    .clear   (accept),
    .capture (cyc_end && !we_q),
    .xfer    (xfer),
    .width   (width_q),
    .rdata   (bus_rdata),
    .word_q  (resp_rdata)
  );

  assign accept  = (st_q == ST_IDLE) && req_valid;
  assign cyc_end = (st_q == ST_BUS) && !bus_rdy_n;
  assign pend_nx = pend_q & ~xfer;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st_q   <= ST_IDLE;
      base_q <= '0;
      pend_q <= '0;
      wd_q   <= '0;
      we_q   <= 1'b0;
    end else begin
      case (st_q)
        ST_IDLE: if (req_valid) begin
          base_q <= req_addr[ADDR_W-1:OFFS_W];
          pend_q <= req_be;
          wd_q   <= req_wdata;
          we_q   <= req_write;
          st_q   <= (req_be == '0) ? ST_DONE : ST_BUS;
        end
        ST_BUS: if (!bus_rdy_n) begin
          pend_q <= pend_nx;
          if (pend_nx == '0) st_q <= ST_DONE;
        end
        default: st_q <= ST_IDLE;
      endcase
    end
  end

  assign req_ready  = (st_q == ST_IDLE);
  assign resp_valid = (st_q == ST_DONE);
  assign bus_cyc    = (st_q == ST_BUS);
  assign bus_write  = we_q;
  assign bus_be     = pend_q;
  assign bus_wdata  = steer;
  assign addr_raw   = {base_q, offs};

  always_comb begin
    bus_addr           = addr_raw;
    bus_addr[MASK_BIT] = addr_raw[MASK_BIT] & a20m_n;
  end

  // R10
  resp_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    resp_valid |=> !resp_valid);

  // R8
  be_live_chk: assert property (@(posedge clk) disable iff (!rst_n)
    bus_cyc |-> (bus_be != '0));

  // R8
  progress_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_cyc && !bus_rdy_n) |=> ($countones(pend_q) < $past($countones(pend_q))));

  // R9
  hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_cyc && bus_rdy_n) |=> (bus_cyc && $stable(bus_be) && $stable(bus_addr[1:0]) && $stable(bus_wdata)));

  // R4
  full_width_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_cyc && !bus_rdy_n && width_q == W32) |=> !bus_cyc);

  // R5
  half_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_cyc && !bus_rdy_n && width_q == W16) |=>
      (($past($countones(pend_q)) - $countones(pend_q)) <= 2));

  // R6
  byte_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_cyc && !bus_rdy_n && width_q == W8) |=>
      (($past($countones(pend_q)) - $countones(pend_q)) == 1));

  // R13
  idle_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (req_ready && !req_valid) |=> req_ready);
endmodule

// File: tb/bsz_splitter_tb_top.sv
`timescale 1ns/1ps
module bsz_splitter_tb_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        req_valid, req_write;
  logic [31:0] req_addr, req_wdata, bus_rdata;
  logic [3:0]  req_be;
  logic        bus_rdy_n, bus_bs16_n, bus_bs8_n, a20m_n;
  logic        req_ready, resp_valid, bus_cyc, bus_write;
  logic [31:0] resp_rdata, bus_addr, bus_wdata;
  logic [3:0]  bus_be;

  always #4 clk = ~clk;

  bsz_splitter dut_i (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
    .req_write(req_write), .req_addr(req_addr), .req_be(req_be), .req_wdata(req_wdata),
    .resp_valid(resp_valid), .resp_rdata(resp_rdata), .bus_cyc(bus_cyc),
    .bus_write(bus_write), .bus_addr(bus_addr), .bus_be(bus_be), .bus_wdata(bus_wdata),
    .bus_rdata(bus_rdata), .bus_rdy_n(bus_rdy_n), .bus_bs16_n(bus_bs16_n),
    .bus_bs8_n(bus_bs8_n), .a20m_n(a20m_n)
  );

  int total = 0;
  int bad = 0;

  // reference model state: 0 idle, 1 bus, 2 done
  int          m_state = 0;
  logic [29:0] m_base;
  logic [3:0]  m_pend;
  logic        m_we;
  logic [31:0] m_wd, m_buf;
  int          m_prev_w = 0;

  // device and stimulus state; width codes: 0=32, 1=16, 2=8, 3=both pins low
  logic [31:0] devmem;
  int          wseq[5];
  int          dev_wait, wait_cnt, cyc_idx, bus_cycles, done_cnt, dut_done;
  bit          glitch, pend_req, first_seen;
  logic        idle_rdy_n;
  logic [31:0] first_addr, got_rdata;

  task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  function automatic int eff_w(input int code);
    return (code == 3) ? 2 : code;
  endfunction

  function automatic logic [1:0] low_idx(input logic [3:0] p);
    for (int i = 0; i < 4; i++) if (p[i]) return 2'(i);
    return 2'd0;
  endfunction

  task automatic set_pins(input int code);
    bus_bs16_n = !(code == 1 || code == 3);
    bus_bs8_n  = !(code == 2 || code == 3);
  endtask

  task automatic step();
    bit rdy = 0;
    int code, w, pw;
    logic [1:0]  lo;
    logic [3:0]  xf;
    logic [31:0] ea, ewd;
    @(negedge clk);
    lo = low_idx(m_pend);
    if (m_state == 1) begin
      rdy = (wait_cnt >= dev_wait);
      bus_rdy_n = !rdy;
      if (rdy && glitch) code = 0;
      else if (rdy)      code = wseq[cyc_idx + 1];
      else               code = wseq[cyc_idx];
      w = eff_w(wseq[cyc_idx]);
      bus_rdata = 32'hEEEE_EEEE;
      if (w == 0)      bus_rdata = devmem;
      else if (w == 1) bus_rdata[15:0] = lo[1] ? devmem[31:16] : devmem[15:0];
      else             bus_rdata[7:0] = devmem[int'(lo)*8 +: 8];
    end else begin
      bus_rdy_n = idle_rdy_n;
      code = wseq[cyc_idx];
    end
    set_pins(code);
    req_valid = pend_req && (m_state == 0);
    #1;
    chk(req_ready == (m_state == 0), "R10 req_ready", 32'(req_ready), 32'(m_state == 0));
    chk(resp_valid == (m_state == 2), "R10 resp_valid", 32'(resp_valid), 32'(m_state == 2));
    chk(bus_cyc == (m_state == 1), "R8 bus_cyc", 32'(bus_cyc), 32'(m_state == 1));
    if (m_state == 1) begin
      ea = {m_base, lo};
      ea[20] = ea[20] & a20m_n;
      ewd = {m_wd[31:16], m_wd[(int'(lo[1])*2 + 1)*8 +: 8], m_wd[int'(lo)*8 +: 8]};
      chk(bus_be == m_pend, "R8 bus_be", 32'(bus_be), 32'(m_pend));
      chk(bus_addr == ea, "R12 bus_addr", bus_addr, ea);
      chk(bus_write == m_we, "R4 bus_write", 32'(bus_write), 32'(m_we));
      if (m_we) chk(bus_wdata == ewd, "R7 bus_wdata", bus_wdata, ewd);
      if (!first_seen) begin first_addr = bus_addr; first_seen = 1; end
      if (rdy && m_we) begin
        if (w == 0) begin
          for (int i = 0; i < 4; i++) if (m_pend[i]) devmem[i*8 +: 8] = bus_wdata[i*8 +: 8];
        end else if (w == 1) begin
          for (int j = 0; j < 2; j++)
            if (m_pend[int'(lo[1])*2 + j]) devmem[(int'(lo[1])*2 + j)*8 +: 8] = bus_wdata[j*8 +: 8];
        end else devmem[int'(lo)*8 +: 8] = bus_wdata[7:0];
      end
    end
    if (m_state == 2) begin
      chk(resp_rdata == m_buf, "R10 resp_rdata", resp_rdata, m_buf);
      got_rdata = resp_rdata;
    end
    if (resp_valid) dut_done++;
    @(posedge clk);
    case (m_state)
      0: if (req_valid) begin
        m_base = req_addr[31:2]; m_pend = req_be; m_we = req_write; m_wd = req_wdata;
        m_buf = '0; pend_req = 0;
        m_state = (req_be == 4'b0) ? 2 : 1;
      end
      1: if (rdy) begin
        pw = m_prev_w;
        if (pw == 0)      xf = m_pend;
        else if (pw == 1) xf = m_pend & (lo[1] ? 4'b1100 : 4'b0011);
        else              xf = 4'b0001 << lo;
        for (int i = 0; i < 4; i++) begin
          if (xf[i] && !m_we) begin
            if (pw == 0)      m_buf[i*8 +: 8] = bus_rdata[i*8 +: 8];
            else if (pw == 1) m_buf[i*8 +: 8] = bus_rdata[(i % 2)*8 +: 8];
            else              m_buf[i*8 +: 8] = bus_rdata[7:0];
          end
        end
        m_pend = m_pend & ~xf;
        bus_cycles++; cyc_idx++; wait_cnt = 0;
        if (m_pend == 4'b0) m_state = 2;
      end else wait_cnt++;
      default: begin m_state = 0; done_cnt++; end
    endcase
    m_prev_w = eff_w(code);
  endtask

  task automatic run_req(input bit we, input logic [31:0] addr, input logic [3:0] be,
                         input logic [31:0] wd, input int c0, input int c1, input int c2,
                         input int c3, input int wt, input bit gl, input int exp_cyc,
                         input logic [31:0] exp_word, input string tag);
    int start_done, start_dut;
    wseq = '{c0, c1, c2, c3, 0};
    dev_wait = wt; glitch = gl; cyc_idx = 0; wait_cnt = 0; bus_cycles = 0; first_seen = 0;
    req_write = we; req_addr = addr; req_be = be; req_wdata = wd; pend_req = 1;
    start_done = done_cnt; start_dut = dut_done;
    while (done_cnt == start_done) step();
    step();
    chk(bus_cycles == exp_cyc, {tag, " cycle count"}, 32'(bus_cycles), 32'(exp_cyc));
    chk(dut_done - start_dut == 1, "R10 single done pulse", 32'(dut_done - start_dut), 32'd1);
    if (we) chk(devmem == exp_word, {tag, " written word"}, devmem, exp_word);
    else    chk(got_rdata == exp_word, {tag, " read word"}, got_rdata, exp_word);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    bad++;
    $display("FAIL R10 watchdog actual=hung expected=done");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    req_valid = 0; req_write = 0; req_addr = '0; req_be = '0; req_wdata = '0;
    bus_rdata = '0; bus_rdy_n = 1; a20m_n = 1; idle_rdy_n = 1; set_pins(0);
    wseq = '{0, 0, 0, 0, 0};
    dev_wait = 0; wait_cnt = 0; cyc_idx = 0; bus_cycles = 0; done_cnt = 0; dut_done = 0;
    glitch = 0; pend_req = 0; first_seen = 0; m_pend = '0; m_buf = '0; m_wd = '0;
    m_base = '0; m_we = 0; devmem = 32'h4433_2211;
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst_n = 1;
    #1;
    chk(req_ready == 1'b1, "R1 reset req_ready", 32'(req_ready), 32'd1);
    chk(bus_cyc == 1'b0, "R1 reset bus_cyc", 32'(bus_cyc), 32'd0);
    chk(resp_valid == 1'b0, "R1 reset resp_valid", 32'(resp_valid), 32'd0);

    // reads from a device holding 44332211
    run_req(0, 32'h0000_1000, 4'hF, '0, 0, 0, 0, 0, 0, 0, 1, 32'h4433_2211, "R4");
    run_req(0, 32'h0000_1004, 4'h6, '0, 0, 0, 0, 0, 1, 0, 1, 32'h0033_2200, "R4");
    run_req(0, 32'h0000_1008, 4'hF, '0, 1, 1, 0, 0, 0, 0, 2, 32'h4433_2211, "R5");
    run_req(0, 32'h0000_100C, 4'hC, '0, 1, 0, 0, 0, 0, 0, 1, 32'h4433_0000, "R5");
    run_req(0, 32'h0000_1010, 4'hF, '0, 2, 2, 2, 2, 1, 0, 4, 32'h4433_2211, "R6");
    run_req(0, 32'h0000_1014, 4'hA, '0, 2, 2, 0, 0, 0, 0, 2, 32'h4400_2200, "R8");
    run_req(0, 32'h0000_1018, 4'hF, '0, 3, 3, 3, 3, 0, 0, 4, 32'h4433_2211, "R2");
    run_req(0, 32'h0000_101C, 4'hF, '0, 2, 2, 2, 2, 1, 1, 4, 32'h4433_2211, "R3");
    run_req(0, 32'h0000_1020, 4'hF, '0, 1, 2, 0, 0, 2, 0, 3, 32'h4433_2211, "R9");
    run_req(0, 32'h0000_1024, 4'h0, '0, 0, 0, 0, 0, 0, 0, 0, 32'h0000_0000, "R11");

    // writes
    devmem = 32'h0;
    run_req(1, 32'h0000_2000, 4'hF, 32'hA1B2_C3D4, 2, 2, 2, 2, 0, 0, 4, 32'hA1B2_C3D4, "R7");
    devmem = 32'h1111_1111;
    run_req(1, 32'h0000_2004, 4'h6, 32'hA1B2_C3D4, 1, 1, 0, 0, 1, 0, 2, 32'h11B2_C311, "R7");
    devmem = 32'h0;
    run_req(1, 32'h0000_2008, 4'h9, 32'hA1B2_C3D4, 0, 0, 0, 0, 0, 0, 1, 32'hA100_00D4, "R4");

    // address bit 20 mask and ignored low address bits
    devmem = 32'h4433_2211;
    a20m_n = 0;
    run_req(0, 32'h0010_0008, 4'hF, '0, 0, 0, 0, 0, 0, 0, 1, 32'h4433_2211, "R12");
    chk(first_addr == 32'h0000_0008, "R12 masked address", first_addr, 32'h0000_0008);
    a20m_n = 1;
    run_req(0, 32'h0010_000B, 4'hC, '0, 0, 0, 0, 0, 0, 0, 1, 32'h4433_0000, "R12");
    chk(first_addr == 32'h0010_000A, "R12 unmasked address", first_addr, 32'h0010_000A);

    // ready pulses while idle
    idle_rdy_n = 0;
    repeat (5) step();
    chk(req_ready == 1'b1 && bus_cyc == 1'b0, "R13 idle ready ignored",
        {30'b0, req_ready, bus_cyc}, 32'h2);
    chk(dut_done == done_cnt, "R13 no spurious done", 32'(dut_done), 32'(done_cnt));
    idle_rdy_n = 1;
    run_req(0, 32'h0000_3000, 4'h3, '0, 2, 2, 0, 0, 0, 0, 2, 32'h0000_2211, "R13");

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule